// File: doc/BRIEF.md
# Tapped Delay Line in Synchronous RAM

This block delays a stream of W-bit samples and exposes N taps spaced M samples apart. It keeps that history in one memory array of M words, each N·W bits wide, instead of in a long chain of flip-flops. A circular address pointer picks one word per shift. The word is read on the rising clock edge and written back on the falling edge of the same period. Each lane of the written word takes the value that was just read from the lane below it, and the lowest lane takes the new sample. The user sees a plain single-clock interface: present a sample, raise `shift_en`, and all N taps update together at that edge.

Typical uses are multi-channel FIR delay lines, correlators and any structure that needs several equally spaced delayed copies of one stream. A longer line can be built by feeding the top tap of one instance into the input of the next. Two capacity budgets can be selected: a small array of 576 bits with an 18-bit word limit, and a large array of 4,608 bits with a 36-bit word limit. A configuration outside the chosen budget is rejected at elaboration.

Top module: `tapped_delay_ram`

## Requirements
- R1: The `taps` output is N·W bits wide. Tap k (k = 1..N) occupies bits [k·W-1 : (k-1)·W], so tap 1 is in the least significant lane.
- R2: When `shift_en` is high at a rising edge, `din` is accepted as sample x_j, where j counts accepted samples from 0 after reset. From that edge on, tap k shows x_(j-k·M) for every k with j ≥ k·M.
- R3: The address pointer steps 0, 1, …, M-1 and then wraps to 0, once per accepted sample. The delay of R2 stays exact over any number of wraps, and is checked beyond 3·N·M accepted samples.
- R4: A rising edge with `shift_en` low changes neither `taps`, `tap_valid` nor the stored history. Later outputs continue as if that cycle had not occurred.
- R5: Reset is synchronous and active-low (`rst_n` = 0 at a rising edge). Reset drives `taps` to zero and `tap_valid` low, and restarts the sample count j and the pointer at 0.
- R6: `tap_valid` goes high at the first accepted sample with j ≥ N·M, which is the point where every tap holds a sample taken since reset. It rises only at an accepted sample and stays high until the next reset.
- R7: The parameter `CAP` selects the budget. 0 means 576 bits of storage and an 18-bit word limit; 1 means 4,608 bits and a 36-bit word limit. Elaboration fails unless W·M·N does not exceed the storage and N·W is below the word limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Reads use the rising edge; the internal write uses the falling edge. |
| rst_n | input | 1 | Synchronous active-low reset. |
| shift_en | input | 1 | Accept `din` and advance the line by one sample. |
| din | input | W | New sample. |
| taps | output | N·W | Packed tap outputs, tap 1 in the lowest lane. |
| tap_valid | output | 1 | High once all taps carry samples taken since reset. |

## Verification
The bench builds the block with W = 4, M = 3, N = 4 on the small budget. That configuration uses 48 of 576 bits and a 16-bit word just below the 18-bit limit. A short tap spacing makes the pointer wrap every three accepted samples, so a few hundred cycles with `shift_en` toggled at random cover dozens of wraps. The same run covers the full N·M fill that gates `tap_valid`, and a reset in the middle of a stream followed by a second fill.

// File: rtl/tdr_pkg.sv
// Package: shared capacity budgets for the tapped delay line.
// Assumes: exactly two budgets exist; CAP_SMALL and CAP_LARGE index them.
package tdr_pkg;

    typedef enum logic {
        CAP_SMALL = 1'b0,
        CAP_LARGE = 1'b1
    } cap_e;

    // Storage bits available under a budget.
    function automatic int cap_bits(input cap_e sel);
        return (sel == CAP_LARGE) ? 4608 : 576;
    endfunction

    // Widest memory word available under a budget.
    function automatic int cap_width(input cap_e sel);
        return (sel == CAP_LARGE) ? 36 : 18;
    endfunction

endpackage

// File: rtl/tdr_ptr.sv
// Module: circular word pointer. It steps by one on each advance and wraps
// from DEPTH-1 back to 0.
// Assumes: DEPTH >= 1 and PW is wide enough to hold DEPTH-1.
module tdr_ptr #(
    parameter int DEPTH = 16,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] ptr_q;

    // Step the pointer with wrap-around; reset returns it to word 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/tdr_fill.sv
// Module: fill tracker. It counts accepted samples up to LIMIT and raises
// valid on the first accepted sample that already has LIMIT samples behind it.
// Assumes: LIMIT >= 1 and CW holds LIMIT.
module tdr_fill #(
    parameter int LIMIT = 64,
    parameter int CW    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic valid
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          valid_q;

    // Saturating count of accepted samples since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (adv && cnt_q != LIM)
            cnt_q <= cnt_q + 1'b1;
    end

    // Valid flag, updated together with the tap register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else if (adv && cnt_q == LIM)
            valid_q <= 1'b1;
    end

    assign valid = valid_q;
endmodule

// File: rtl/tdr_ram.sv
// Module: single-port array with a registered read on the rising edge and a
// write on the falling edge. A read and a write to the same word within one
// period therefore see old data on the read and new data stored afterwards.
// Assumes: the caller keeps wr_* stable from the rising edge to the falling edge.
module tdr_ram #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    // Rising-edge read into the output register; reset clears the register only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= mem[rd_addr];
    end

    // Falling-edge write of the word assembled during the first half period.
    always_ff @(negedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/tapped_delay_ram.sv
// Module: top of the tapped delay line. It holds W x M x N bits of history in
// one RAM of M words of N lanes. Each accepted sample reads the word at the
// pointer (rising edge), presents it as the taps, and writes it back moved up
// one lane with the new sample in lane 0 (falling edge).
// Assumes: W, M, N >= 1, and the configuration fits the budget chosen by CAP (R7).
module tapped_delay_ram
    import tdr_pkg::*;
#(
    parameter int   W   = 8,
    parameter int   M   = 16,
    parameter int   N   = 4,
    parameter cap_e CAP = CAP_LARGE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic [W-1:0]   din,
    output logic [N*W-1:0] taps,
    output logic           tap_valid
);
    localparam int DW    = N * W;
    localparam int PW    = (M > 1) ? $clog2(M) : 1;
    localparam int FILL  = N * M;
    localparam int CW    = $clog2(FILL + 1);
    localparam int BITS  = W * M * N;

    // R7: reject configurations outside the selected budget.
    generate
        if (BITS > cap_bits(CAP)) begin : g_bits_err
            $error("tapped_delay_ram: W*M*N exceeds the selected storage budget");
        end
        if (DW >= cap_width(CAP)) begin : g_width_err
            $error("tapped_delay_ram: N*W must stay below the selected word limit");
        end
    endgenerate

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] wr_addr_q;
    logic          wr_pend_q;
    logic [W-1:0]  din_l_q;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] wr_word;

    // Pointer of the word used by the current sample (R3).
    tdr_ptr #(.DEPTH(M), .PW(PW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_en),
        .ptr   (ptr_q)
    );

    // Hold the write request for the falling edge of the same period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend_q <= 1'b0;
            wr_addr_q <= '0;
            din_l_q   <= '0;
        end else begin
            wr_pend_q <= shift_en;
            if (shift_en) begin
                wr_addr_q <= ptr_q;
                din_l_q   <= din;
            end
        end
    end

    // Build the write-back word: lanes move up by one, the new sample enters lane 0.
    generate
        if (N == 1) begin : g_one_lane
            assign wr_word = din_l_q;
        end else begin : g_lanes
            assign wr_word = {rd_word[DW-W-1:0], din_l_q};
        end
    endgenerate

    // History storage with read-then-write inside one clock period.
    tdr_ram #(.DEPTH(M), .DW(DW), .AW(PW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (shift_en),
        .rd_addr (ptr_q),
        .rd_data (rd_word),
        .wr_en   (wr_pend_q),
        .wr_addr (wr_addr_q),
        .wr_data (wr_word)
    );

    // Validity tracking (R6).
    tdr_fill #(.LIMIT(FILL), .CW(CW)) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_en),
        .valid (tap_valid)
    );

    assign taps = rd_word;
endmodule

// File: rtl/tapped_delay_ram_chk.sv
// Module: assertion checker for tapped_delay_ram, attached with bind.
// Assumes: ptr is the top's internal word pointer.
module tapped_delay_ram_chk #(
    parameter int M  = 16,
    parameter int PW = 4,
    parameter int N  = 4,
    parameter int W  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           shift_en,
    input logic [PW-1:0]  ptr,
    input logic [N*W-1:0] taps,
    input logic           tap_valid
);
    logic [PW-1:0] ptr_nxt;

    // Expected successor of the pointer, used to check the wrap.
    always_comb begin
        if (ptr == PW'(M - 1)) ptr_nxt = '0;
        else                   ptr_nxt = ptr + 1'b1;
    end

    p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(M - 1));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> ptr == $past(ptr_nxt));

    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(ptr));

    p_taps_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(taps) && $stable(tap_valid));

    p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tap_valid |=> tap_valid);

    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tap_valid) |-> $past(shift_en));
endmodule

bind tapped_delay_ram tapped_delay_ram_chk #(.M(M), .PW(PW), .N(N), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .ptr       (ptr_q),
    .taps      (taps),
    .tap_valid (tap_valid)
);

// File: tb/tapped_delay_ram_tb.sv
// Bench: scoreboard. The driver task pushes the expected tap word for every
// cycle it drives; the monitor pops and compares one rising edge later.
module tapped_delay_ram_tb;
    import tdr_pkg::*;

    localparam int W = 4;
    localparam int M = 3;
    localparam int N = 4;
    localparam cap_e CAP = CAP_SMALL;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           shift_en = 1'b0;
    logic [W-1:0]   din = '0;
    logic [N*W-1:0] taps;
    logic           tap_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [W-1:0]   hist[$];
    logic [N*W-1:0] cur_taps, cur_mask;
    logic           cur_valid;

    logic [N*W-1:0] q_taps[$];
    logic [N*W-1:0] q_mask[$];
    logic           q_valid[$];
    string          q_tag[$];

    always #2 clk = ~clk;

    tapped_delay_ram #(.W(W), .M(M), .N(N), .CAP(CAP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (din),
        .taps      (taps),
        .tap_valid (tap_valid)
    );

    // Driver: set inputs after the falling edge and push the expected result.
    task automatic drive(input bit en, input logic [W-1:0] d, input string tag);
        @(posedge clk);
        #3;
        shift_en = en;
        din      = d;
        if (en) begin
            int j;
            hist.push_back(d);
            j = hist.size() - 1;
            for (int k = 1; k <= N; k++) begin
                if (j >= k * M) begin
                    cur_taps[(k-1)*W +: W] = hist[j - k*M];
                    cur_mask[(k-1)*W +: W] = '1;
                end else begin
                    cur_taps[(k-1)*W +: W] = '0;
                    cur_mask[(k-1)*W +: W] = '0;
                end
            end
            cur_valid = (j >= N * M);
        end
        q_taps.push_back(cur_taps);
        q_mask.push_back(cur_mask);
        q_valid.push_back(cur_valid);
        if (tag != "")            q_tag.push_back(tag);
        else if (!en)             q_tag.push_back("R4");
        else if (hist.size() > 3*N*M) q_tag.push_back("R3");
        else                      q_tag.push_back("R2");
    endtask

    // Reset for two edges; the model restarts with zero taps (R5).
    task automatic do_reset();
        @(posedge clk);
        #3;
        rst_n    = 1'b0;
        shift_en = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        rst_n = 1'b1;
        hist.delete();
        cur_taps  = '0;
        cur_mask  = '1;
        cur_valid = 1'b0;
    endtask

    // Monitor: compare the outputs one time unit after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_taps.size() != 0) begin
                logic [N*W-1:0] et, em;
                logic           ev;
                string          tg;
                et = q_taps.pop_front();
                em = q_mask.pop_front();
                ev = q_valid.pop_front();
                tg = q_tag.pop_front();
                n_chk++;
                if (((taps ^ et) & em) != '0) begin
                    n_bad++;
                    $display("FAIL %s taps: got %h expected %h (mask %h)", tg, taps, et, em);
                end else if (tap_valid !== ev) begin
                    n_bad++;
                    $display("FAIL R6 tap_valid (%s): got %b expected %b", tg, tap_valid, ev);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        n_chk++;
        if ($bits(taps) != N * W) begin
            n_bad++;
            $display("FAIL R1 tap width: got %0d expected %0d", $bits(taps), N * W);
        end
        n_chk++;
        if (!(W*M*N <= 576 && N*W < 18)) begin
            n_bad++;
            $display("FAIL R7 budget: got %0d bits/%0d wide expected <=576/<18", W*M*N, N*W);
        end

        do_reset();
        drive(1'b0, '0, "R5");
        drive(1'b0, 4'h9, "R5");
        // Incrementing samples fill every lane (R1 lane order, R2, R6 edge).
        for (int i = 0; i < 2*N*M; i++) drive(1'b1, W'(i + 1), "");
        for (int i = 0; i < 5; i++) drive(1'b0, W'(15 - i), "R4");
        // Random enables across many pointer wraps (R3).
        for (int i = 0; i < 200; i++) drive(($urandom_range(0, 9) < 7), W'($urandom), "");

        // Reset in the middle of a valid stream (R5), then a second fill (R6).
        repeat (3) @(posedge clk);
        do_reset();
        drive(1'b0, 4'h5, "R5");
        for (int i = 0; i < 150; i++) drive(($urandom_range(0, 9) < 6), W'($urandom), "");
        drive(1'b0, '0, "R4");

        while (q_taps.size() != 0) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule